// File: doc/BRIEF.md
# Timer Interrupt Vector Generator

This block gathers the pending flags of a timer with seven capture/compare channels (0 to 6) and an overflow source, and turns them into interrupt requests. Each flag is set by a one-cycle event pulse from the counter, capture or compare logic, which lies outside this block. Software can also set or clear any flag through a small register bus.

Channel 0 has the highest priority and its own request line. The interrupt controller acknowledges that line, and the acknowledge clears the channel 0 flag. Channels 1 to 6 and the overflow source share a second request line. A vector register reports the highest-priority source that is both pending and enabled. Any bus access to the vector register, read or write, clears that one flag. The next enabled pending source then keeps the shared request asserted.

Top module: `tmr_irq_vector`

## Requirements
- R1: After reset, the flag register and the enable register read 0, both request outputs are low, and a vector read returns 0.
- R2: An event pulse on a source sets that source's flag, and the flag is visible from the next clock edge. Channel k uses flag bit k, and overflow uses flag bit 7.
- R3: `ch0_irq` is high exactly when flag 0, enable bit 0 and `gie` are all set. `shared_irq` is high when `gie` is set and any of flags 1 to 7 is set with its enable bit set.
- R4: The vector reads as 0x00 when no enabled source from 1 to 7 is pending. It reads as 2·k for channel k (1 to 6) and 0x0E for overflow. The lowest pending index wins. Channel 0 never shows in the vector. Bus addresses: 0 is flags, 1 is enables (bit layout as in R2), and 2 is the vector.
- R5: A flag whose enable bit is clear does not affect the vector value. A vector access does not clear it.
- R6: A read or a write at address 2 clears only the flag that the vector reports. A read returns the vector value from before the clear.
- R7: After a vector access, `shared_irq` stays asserted while any other enabled flag from 1 to 7 is still pending.
- R8: A pulse on `ch0_ack` clears flag 0.
- R9: A write to address 0 loads all eight flags from `bus_wdata[7:0]`, which sets or clears each flag.
- R10: If an event pulse arrives on a flag in the same cycle that a clear (vector access or acknowledge) hits that flag, the flag stays set.
- R11: With `gie` low, both request outputs stay low. The vector still reports the pending enabled source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 7 | Capture/compare event pulses, bit k for channel k |
| ovf_evt | input | 1 | Timer overflow event pulse |
| gie | input | 1 | Global interrupt enable |
| ch0_ack | input | 1 | Channel 0 request accepted |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| ch0_irq | output | 1 | Channel 0 dedicated request |
| shared_irq | output | 1 | Shared request for channels 1 to 6 and overflow |

## Verification
A hardware event can land in the same cycle as a clear of the same flag. The clear comes either from a vector-register access or from the channel 0 acknowledge. The bench provokes this by driving the event pulse together with the vector read strobe, on the flag the vector currently reports. It then judges two things. The read must return the value from before the access. A separate read of the flag register must still show that flag set.

// File: rtl/tmr_irq_vector.sv
module tmr_irq_vector #(
  parameter int NCH = 7,
  parameter int DW  = 16,
  parameter int AW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] evt,
  input  logic          ovf_evt,
  input  logic          gie,
  input  logic          ch0_ack,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          ch0_irq,
  output logic          shared_irq
);
  localparam int NF = NCH + 1;
  localparam int IW = $clog2(NF);

  logic [NF-1:0] flags, enab, nxt, pend, evt_all;
  logic [IW-1:0] hi_idx;
  logic          any_pend;
  logic [DW-1:0] vec;

  wire wr_flags = bus_sel && bus_we && (bus_addr == AW'(0));
  wire wr_enab  = bus_sel && bus_we && (bus_addr == AW'(1));
  wire vacc     = bus_sel && (bus_addr == AW'(2));

  assign evt_all  = {ovf_evt, evt};
  assign pend     = flags & enab & {{(NF-1){1'b1}}, 1'b0};
  assign any_pend = |pend;

  always_comb begin
    hi_idx = '0;
    for (int i = NF-1; i >= 1; i--)
      if (pend[i]) hi_idx = IW'(i);
  end

  assign vec = any_pend ? (DW'(hi_idx) << 1) : '0;

  always_comb begin
    nxt = flags;
    if (wr_flags) nxt = bus_wdata[NF-1:0];
    if (vacc && any_pend) nxt[hi_idx] = 1'b0;
    if (ch0_ack) nxt[0] = 1'b0;
    nxt = nxt | evt_all;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      enab  <= '0;
    end else begin
      flags <= nxt;
      if (wr_enab) enab <= bus_wdata[NF-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      AW'(0):  bus_rdata = DW'(flags);
      AW'(1):  bus_rdata = DW'(enab);
      AW'(2):  bus_rdata = vec;
      default: bus_rdata = '0;
    endcase
  end

  assign ch0_irq    = gie && flags[0] && enab[0];
  assign shared_irq = gie && any_pend;

  // R2
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_all) |=> ((flags & $past(evt_all)) == $past(evt_all)));

  // R6
  vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vacc && any_pend && !evt_all[hi_idx]) |=> !flags[$past(hi_idx)]);

  // R6
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vacc && !(|evt_all) && !ch0_ack && !wr_flags) |=> ($countones(flags ^ $past(flags)) <= 1));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0_ack && !evt_all[0]) |=> !flags[0]);

  // R11
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (!ch0_irq && !shared_irq));
endmodule

// File: tb/tmr_irq_vector_test.sv
module tmr_irq_vector_test;
  logic        clk = 0, rst_n = 0;
  logic [6:0]  evt = '0;
  logic        ovf_evt = 0, gie = 0, ch0_ack = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        ch0_irq, shared_irq;
  int nchk = 0, nfail = 0;
  logic [15:0] r;

  tmr_irq_vector uut (.clk, .rst_n, .evt, .ovf_evt, .gie, .ch0_ack, .bus_sel, .bus_we,
                      .bus_addr, .bus_wdata, .bus_rdata, .ch0_irq, .shared_irq);

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(logic [7:0] e);
    @(negedge clk); evt = e[6:0]; ovf_evt = e[7];
    @(negedge clk); evt = '0; ovf_evt = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic t_reset;
    rd(2'd0, r); chk("R1 flags", r, 16'h0);
    rd(2'd1, r); chk("R1 enables", r, 16'h0);
    rd(2'd2, r); chk("R1 vector", r, 16'h0);
    chk("R1 irqs", {14'b0, ch0_irq, shared_irq}, 16'h0);
  endtask

  task automatic t_event;
    wr(2'd1, 16'h00FF); gie = 1;
    pulse(8'h04);
    rd(2'd0, r); chk("R2 flag ch2", r, 16'h0004);
    chk("R3 shared high", {15'b0, shared_irq}, 16'h1);
    rd(2'd2, r); chk("R4 vector ch2", r, 16'h0004);
    rd(2'd0, r); chk("R6 flag cleared", r, 16'h0);
    chk("R3 shared low", {15'b0, shared_irq}, 16'h0);
  endtask

  task automatic t_priority;
    pulse(8'h86);
    rd(2'd2, r); chk("R4 vector ch1 first", r, 16'h0002);
    chk("R7 shared stays", {15'b0, shared_irq}, 16'h1);
    rd(2'd2, r); chk("R4 vector ch2 next", r, 16'h0004);
    rd(2'd2, r); chk("R4 vector overflow", r, 16'h000E);
    chk("R7 shared drops", {15'b0, shared_irq}, 16'h0);
    rd(2'd2, r); chk("R4 vector none", r, 16'h0000);
  endtask

  task automatic t_mask;
    wr(2'd1, 16'h00F9);
    pulse(8'h06);
    chk("R5 masked no request", {15'b0, shared_irq}, 16'h0);
    rd(2'd2, r); chk("R5 masked vector", r, 16'h0);
    rd(2'd0, r); chk("R5 masked flags kept", r, 16'h0006);
    pulse(8'h08);
    rd(2'd2, r); chk("R5 vector skips masked", r, 16'h0006);
    rd(2'd0, r); chk("R5 only ch3 cleared", r, 16'h0006);
    wr(2'd0, 16'h0); wr(2'd1, 16'h00FF);
  endtask

  task automatic t_write_access;
    pulse(8'h30);
    wr(2'd2, 16'hFFFF);
    rd(2'd0, r); chk("R6 write access clears ch4", r, 16'h0020);
    rd(2'd2, r); chk("R4 vector ch5", r, 16'h000A);
  endtask

  task automatic t_ch0;
    pulse(8'h01);
    chk("R3 ch0 request", {14'b0, ch0_irq, shared_irq}, 16'h2);
    rd(2'd2, r); chk("R4 ch0 not in vector", r, 16'h0);
    rd(2'd0, r); chk("R4 ch0 flag kept", r, 16'h0001);
    @(negedge clk); ch0_ack = 1; @(negedge clk); ch0_ack = 0;
    rd(2'd0, r); chk("R8 ack clears ch0", r, 16'h0);
    chk("R8 ch0 request low", {15'b0, ch0_irq}, 16'h0);
  endtask

  task automatic t_sw;
    wr(2'd0, 16'h0041);
    rd(2'd0, r); chk("R9 sw set", r, 16'h0041);
    chk("R9 ch0 request from sw", {15'b0, ch0_irq}, 16'h1);
    rd(2'd2, r); chk("R9 vector ch6", r, 16'h000C);
    wr(2'd0, 16'h0081);
    wr(2'd0, 16'h0000);
    rd(2'd0, r); chk("R9 sw clear", r, 16'h0);
  endtask

  task automatic t_collide;
    pulse(8'h02);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = 2'd2; evt = 7'h02;
    #1 chk("R10 pre-clear vector", bus_rdata, 16'h0002);
    @(negedge clk); bus_sel = 0; evt = '0;
    rd(2'd0, r); chk("R10 event beats clear", r, 16'h0002);
    @(negedge clk); ch0_ack = 1; evt = 7'h01;
    @(negedge clk); ch0_ack = 0; evt = '0;
    rd(2'd0, r); chk("R10 event beats ack", r, 16'h0003);
    wr(2'd0, 16'h0);
  endtask

  task automatic t_gie;
    gie = 0;
    pulse(8'h03);
    chk("R11 requests gated", {14'b0, ch0_irq, shared_irq}, 16'h0);
    rd(2'd2, r); chk("R11 vector without gie", r, 16'h0002);
    gie = 1; #1;
    chk("R11 ch0 after gie", {14'b0, ch0_irq, shared_irq}, 16'h2);
    wr(2'd0, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_event;
    t_priority;
    t_mask;
    t_write_access;
    t_ch0;
    t_sw;
    t_collide;
    t_gie;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule